// File: doc/BRIEF.md
# Flash Multi-Block Erase Sequencer

This block runs a self-timed erase over a set of flash blocks that software picks. Software first writes a block-select mask while the high-voltage enable is low. It then raises erase-select and gives the enable a rising edge. The sequencer takes a snapshot of the blocks that may be erased: selected, not locked, and not the test block. It then erases them one after another with no further software action, filling each word of each block with all ones. When the last block has been handled it raises done and reports through the pass flag whether every erased block reads back all ones.

The array is a small behavioural model inside the block. It comes out of reset with every word cleared, it has a combinational read port for observation, and its write strobes appear on the ports. The low blocks come first in the mask, then the mid blocks, then one shadow block, and the test block sits in the top bit. The order in which the snapshot is worked through is a build-time choice, and no user of the block may rely on it. Dropping the enable during an erase ends the sequence at the next edge.

Top module: `flash_erase_seq`

## Requirements
- R1: Every word of each block that is erased is written with all ones. The array write port only ever carries all-ones data.
- R2: Mask bit i selects block i. Bits 0..LOW_BLKS-1 are the low blocks, the next MID_BLKS bits are the mid blocks, bit LOW_BLKS+MID_BLKS is the shadow block, and the top bit LOW_BLKS+MID_BLKS+1 is the test block. Any mix of low, mid and shadow blocks is erased in one sequence.
- R3: The test block is never written, whatever the mask holds. A mask whose only erasable bit would be the test block counts as empty.
- R4: A block whose lockMask bit is 1 at the enable edge is not written, even when it is selected.
- R5: A sequence starts only on a rising edge of hvEn while eraseSel is 1 and the erasable set is not empty. done falls one cycle after that edge. An enable edge with eraseSel at 0 changes nothing.
- R6: If the erasable set is empty at a qualifying enable edge, done stays 1 and pass is 0 from the next cycle on.
- R7: With N blocks erased, done is 0 for exactly N*CYC_PER_BLK cycles and then returns to 1.
- R8: On normal completion pass is 1 exactly when every erased block reads back all ones. pass is 0 while an erase is running.
- R9: If hvEn is 0 while done is 0, the next cycle has done 1 and pass 0. Blocks outside the snapshot keep their contents. Blocks inside it are undefined.
- R10: A mask write (maskWrEn) takes effect only while hvEn is 0. A falling edge of eraseSel clears the mask, and this clear wins over a write in the same cycle.
- R11: Array writes occur only while done is 0, only to blocks in the snapshot, and exactly WORDS_PER_BLK writes are made per erased block.
- R12: After reset done is 1, pass is 0, the mask is 0 and every array word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| eraseSel | input | 1 | Erase operation selected |
| hvEn | input | 1 | High-voltage enable; rising edge starts, low aborts |
| maskWrEn | input | 1 | Write strobe for the block-select mask |
| maskWrData | input | NBLK | New block-select mask |
| lockMask | input | NBLK | 1 = block locked against erase |
| selMask | output | NBLK | Current block-select mask |
| done | output | 1 | 1 when no erase is running |
| pass | output | 1 | Result of the last sequence |
| arrWrEn | output | 1 | Array write strobe |
| arrWrBlk | output | BLK_W | Block being written |
| arrWrWord | output | IDX_W | Word being written |
| arrWrData | output | WORD_W | Data being written |
| rdBlk | input | BLK_W | Read port block index |
| rdWord | input | IDX_W | Read port word index |
| rdData | output | WORD_W | Array word at rdBlk/rdWord |

## Verification
The bench builds the block with two low blocks, one mid block, four 16-bit words per block, six cycles per block and the highest-index-first order. This gives five blocks, so a single run can select every region including the test bit, and the non-default order variant gets built. The short block period keeps multi-block runs and mid-block aborts within a few dozen cycles, and a six-cycle period with four words leaves idle verify cycles after the writes, so the exact done-low length can be checked. Expected contents are given per block as ones, zeros or undefined, so no check depends on the erase order.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ERASE = 1'b1
  } eraseState_e;

  // strobes from the sequencing control to the datapath
  typedef struct packed {
    logic snap;     // capture erasable set and pick the first block
    logic advance;  // retire current block and pick the next one
    logic flush;    // drop the pending set (abort)
    logic wrEn;     // write all ones to the current word
  } dpStrobe_t;

endpackage

// File: rtl/flash_erase_dp.sv
module flash_erase_dp
  import flash_erase_pkg::*;
#(
  parameter int LOW_BLKS      = 2,
  parameter int MID_BLKS      = 2,
  parameter int WORDS_PER_BLK = 4,
  parameter int WORD_W        = 32,
  parameter bit HIGH_FIRST    = 1'b0,
  localparam int NBLK  = LOW_BLKS + MID_BLKS + 2,
  localparam int BLK_W = $clog2(NBLK),
  localparam int IDX_W = $clog2(WORDS_PER_BLK)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eraseSel,
  input  logic              hvEn,
  input  logic              maskWrEn,
  input  logic [NBLK-1:0]   maskWrData,
  input  logic [NBLK-1:0]   lockMask,
  input  dpStrobe_t         strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [BLK_W-1:0]  rdBlk,
  input  logic [IDX_W-1:0]  rdWord,
  output logic [NBLK-1:0]   selMask,
  output logic              anyErasable,
  output logic              moreLeft,
  output logic              blkAllOnes,
  output logic              arrWrEn,
  output logic [BLK_W-1:0]  arrWrBlk,
  output logic [IDX_W-1:0]  arrWrWord,
  output logic [WORD_W-1:0] arrWrData,
  output logic [WORD_W-1:0] rdData
);

  localparam logic [NBLK-1:0] TEST_BIT = {1'b1, {(NBLK-1){1'b0}}};

  logic              eselQ;
  logic [NBLK-1:0]   pending;
  logic [BLK_W-1:0]  curBlk;
  logic [NBLK-1:0]   curBit;
  logic [NBLK-1:0]   erasable;
  logic [NBLK-1:0]   remaining;
  logic [NBLK-1:0]   pickSrc;
  logic [BLK_W-1:0]  pickOut;
  logic [WORD_W-1:0] mem [NBLK][WORDS_PER_BLK];

  // mask register: erase-select falling edge clears, writes only with HV off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eselQ   <= 1'b0;
      selMask <= '0;
    end else begin
      eselQ <= eraseSel;
      if (eselQ && !eraseSel)
        selMask <= '0;
      else if (maskWrEn && !hvEn)
        selMask <= maskWrData;
    end
  end

  assign erasable    = selMask & ~lockMask & ~TEST_BIT;
  assign anyErasable = |erasable;
  assign curBit      = NBLK'(1) << curBlk;
  assign remaining   = pending & ~curBit;
  assign moreLeft    = |remaining;
  assign pickSrc     = strb.snap ? erasable : remaining;

  // block pick order is a build-time variant
  generate
    if (HIGH_FIRST) begin : g_pickHigh
      always_comb begin
        pickOut = '0;
        for (int i = 0; i < NBLK; i++)
          if (pickSrc[i]) pickOut = BLK_W'(i);
      end
    end else begin : g_pickLow
      always_comb begin
        pickOut = '0;
        for (int i = NBLK - 1; i >= 0; i--)
          if (pickSrc[i]) pickOut = BLK_W'(i);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
      curBlk  <= '0;
    end else if (strb.snap) begin
      pending <= erasable;
      curBlk  <= pickOut;
    end else if (strb.flush) begin
      pending <= '0;
    end else if (strb.advance) begin
      pending <= remaining;
      curBlk  <= pickOut;
    end
  end

  // behavioural array
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NBLK; b++)
        for (int w = 0; w < WORDS_PER_BLK; w++)
          mem[b][w] <= '0;
    end else if (strb.wrEn) begin
      mem[curBlk][wrIdx] <= '1;
    end
  end

  // verify: whole current block must read all ones
  always_comb begin
    blkAllOnes = 1'b1;
    for (int w = 0; w < WORDS_PER_BLK; w++)
      if (mem[curBlk][w] != {WORD_W{1'b1}}) blkAllOnes = 1'b0;
  end

  assign rdData    = (int'(rdBlk) < NBLK) ? mem[rdBlk][rdWord] : '0;
  assign arrWrEn   = strb.wrEn;
  assign arrWrBlk  = curBlk;
  assign arrWrWord = wrIdx;
  assign arrWrData = '1;

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_erase_pkg::*;
#(
  parameter int WORDS_PER_BLK = 4,
  parameter int CYC_PER_BLK   = 8,
  localparam int IDX_W = $clog2(WORDS_PER_BLK),
  localparam int CNT_W = $clog2(CYC_PER_BLK)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             eraseSel,
  input  logic             hvEn,
  input  logic             anyErasable,
  input  logic             moreLeft,
  input  logic             blkAllOnes,
  output dpStrobe_t        strb,
  output logic [IDX_W-1:0] wrIdx,
  output logic             done,
  output logic             pass
);

  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(CYC_PER_BLK - 1);
  localparam logic [CNT_W-1:0] CNT_WORDS = CNT_W'(WORDS_PER_BLK);

  eraseState_e     state;
  logic [CNT_W-1:0] cnt;
  logic            hvEnQ;
  logic            passAcc;
  logic            startEdge;
  logic            blkEnd;

  assign startEdge = hvEn && !hvEnQ && eraseSel;
  assign blkEnd    = (cnt == CNT_LAST);
  assign wrIdx     = cnt[IDX_W-1:0];

  always_comb begin
    strb = '0;
    unique case (state)
      ST_IDLE: strb.snap = startEdge && anyErasable;
      ST_ERASE: begin
        if (!hvEn) begin
          strb.flush = 1'b1;
        end else begin
          strb.wrEn    = (cnt < CNT_WORDS);
          strb.advance = blkEnd && moreLeft;
        end
      end
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      hvEnQ   <= 1'b0;
      passAcc <= 1'b0;
      done    <= 1'b1;
      pass    <= 1'b0;
    end else begin
      hvEnQ <= hvEn;
      unique case (state)
        ST_IDLE: begin
          if (startEdge) begin
            pass <= 1'b0;
            if (anyErasable) begin
              state   <= ST_ERASE;
              cnt     <= '0;
              passAcc <= 1'b1;
              done    <= 1'b0;
            end
          end
        end
        ST_ERASE: begin
          if (!hvEn) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            pass  <= 1'b0;
          end else if (blkEnd) begin
            cnt     <= '0;
            passAcc <= passAcc & blkAllOnes;
            if (!moreLeft) begin
              state <= ST_IDLE;
              done  <= 1'b1;
              pass  <= passAcc & blkAllOnes;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int LOW_BLKS      = 2,
  parameter int MID_BLKS      = 2,
  parameter int WORDS_PER_BLK = 4,
  parameter int WORD_W        = 32,
  parameter int CYC_PER_BLK   = 8,
  parameter bit HIGH_FIRST    = 1'b0,
  localparam int NBLK  = LOW_BLKS + MID_BLKS + 2,
  localparam int BLK_W = $clog2(NBLK),
  localparam int IDX_W = $clog2(WORDS_PER_BLK)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eraseSel,
  input  logic              hvEn,
  input  logic              maskWrEn,
  input  logic [NBLK-1:0]   maskWrData,
  input  logic [NBLK-1:0]   lockMask,
  output logic [NBLK-1:0]   selMask,
  output logic              done,
  output logic              pass,
  output logic              arrWrEn,
  output logic [BLK_W-1:0]  arrWrBlk,
  output logic [IDX_W-1:0]  arrWrWord,
  output logic [WORD_W-1:0] arrWrData,
  input  logic [BLK_W-1:0]  rdBlk,
  input  logic [IDX_W-1:0]  rdWord,
  output logic [WORD_W-1:0] rdData
);

  dpStrobe_t        strb;
  logic [IDX_W-1:0] wrIdx;
  logic             anyErasable;
  logic             moreLeft;
  logic             blkAllOnes;

  flash_erase_ctrl #(
    .WORDS_PER_BLK(WORDS_PER_BLK),
    .CYC_PER_BLK  (CYC_PER_BLK)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .eraseSel   (eraseSel),
    .hvEn       (hvEn),
    .anyErasable(anyErasable),
    .moreLeft   (moreLeft),
    .blkAllOnes (blkAllOnes),
    .strb       (strb),
    .wrIdx      (wrIdx),
    .done       (done),
    .pass       (pass)
  );

  flash_erase_dp #(
    .LOW_BLKS     (LOW_BLKS),
    .MID_BLKS     (MID_BLKS),
    .WORDS_PER_BLK(WORDS_PER_BLK),
    .WORD_W       (WORD_W),
    .HIGH_FIRST   (HIGH_FIRST)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .eraseSel   (eraseSel),
    .hvEn       (hvEn),
    .maskWrEn   (maskWrEn),
    .maskWrData (maskWrData),
    .lockMask   (lockMask),
    .strb       (strb),
    .wrIdx      (wrIdx),
    .rdBlk      (rdBlk),
    .rdWord     (rdWord),
    .selMask    (selMask),
    .anyErasable(anyErasable),
    .moreLeft   (moreLeft),
    .blkAllOnes (blkAllOnes),
    .arrWrEn    (arrWrEn),
    .arrWrBlk   (arrWrBlk),
    .arrWrWord  (arrWrWord),
    .arrWrData  (arrWrData),
    .rdData     (rdData)
  );

endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk #(
  parameter int LOW_BLKS      = 2,
  parameter int MID_BLKS      = 2,
  parameter int WORDS_PER_BLK = 4,
  parameter int WORD_W        = 32,
  localparam int NBLK  = LOW_BLKS + MID_BLKS + 2,
  localparam int BLK_W = $clog2(NBLK)
) (
  input logic              clk,
  input logic              rstN,
  input logic              eraseSel,
  input logic              hvEn,
  input logic [NBLK-1:0]   selMask,
  input logic              done,
  input logic              pass,
  input logic              arrWrEn,
  input logic [BLK_W-1:0]  arrWrBlk,
  input logic [WORD_W-1:0] arrWrData
);

  localparam logic [BLK_W-1:0] TEST_IDX = BLK_W'(NBLK - 1);

  AST_WR_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> (arrWrData == {WORD_W{1'b1}})); // R1

  AST_TEST_BLK_UNTOUCHED: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> (arrWrBlk != TEST_IDX)); // R3

  AST_DONE_FALL_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    $fell(done) |-> ($past(hvEn) && $past(eraseSel))); // R5

  AST_WR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> !done); // R11

  AST_NO_PASS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> !pass); // R8

  AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (!done && !hvEn) |=> (done && !pass)); // R9

  AST_MASK_HOLD_HV: assert property (@(posedge clk) disable iff (!rstN)
    ($past(hvEn) && $past(eraseSel)) |-> $stable(selMask)); // R10

  AST_MASK_CLR_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eraseSel) |=> (selMask == '0)); // R10

endmodule

bind flash_erase_seq flash_erase_seq_chk #(
  .LOW_BLKS     (LOW_BLKS),
  .MID_BLKS     (MID_BLKS),
  .WORDS_PER_BLK(WORDS_PER_BLK),
  .WORD_W       (WORD_W)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .eraseSel (eraseSel),
  .hvEn     (hvEn),
  .selMask  (selMask),
  .done     (done),
  .pass     (pass),
  .arrWrEn  (arrWrEn),
  .arrWrBlk (arrWrBlk),
  .arrWrData(arrWrData)
);

// File: tb/test_flash_erase_seq.sv
`timescale 1ns/1ps
module test_flash_erase_seq;

  localparam int LOW   = 2;
  localparam int MID   = 1;
  localparam int WORDS = 4;
  localparam int WW    = 16;
  localparam int CYC   = 6;
  localparam int NBLK  = LOW + MID + 2;
  localparam int BLK_W = $clog2(NBLK);
  localparam int IDX_W = $clog2(WORDS);

  logic              clk = 1'b0;
  logic              rstN;
  logic              eraseSel, hvEn, maskWrEn;
  logic [NBLK-1:0]   maskWrData, lockMask, selMask;
  logic              done, pass, arrWrEn;
  logic [BLK_W-1:0]  arrWrBlk, rdBlk;
  logic [IDX_W-1:0]  arrWrWord, rdWord;
  logic [WW-1:0]     arrWrData, rdData;

  always #2.5 clk = ~clk;

  flash_erase_seq #(
    .LOW_BLKS(LOW), .MID_BLKS(MID), .WORDS_PER_BLK(WORDS),
    .WORD_W(WW), .CYC_PER_BLK(CYC), .HIGH_FIRST(1'b1)
  ) i_flash_erase_seq (
    .clk(clk), .rstN(rstN), .eraseSel(eraseSel), .hvEn(hvEn),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData), .lockMask(lockMask),
    .selMask(selMask), .done(done), .pass(pass), .arrWrEn(arrWrEn),
    .arrWrBlk(arrWrBlk), .arrWrWord(arrWrWord), .arrWrData(arrWrData),
    .rdBlk(rdBlk), .rdWord(rdWord), .rdData(rdData)
  );

  typedef struct {
    string           tag;
    int              expCyc;   // negedges until done high; 0 = not checked
    bit              expPass;
    logic [NBLK-1:0] onesMask; // blocks expected all ones
    logic [NBLK-1:0] dcMask;   // blocks with undefined contents
    bit              chkCount;
  } expItem_t;

  expItem_t expQ[$];
  bit       monBusy = 1'b0;
  int       nChecks = 0;
  int       nErrors = 0;
  bit       finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  endtask

  // monitor: pops expected items and compares against the design
  initial begin
    forever begin
      expItem_t it;
      int n;
      int wrCnt;
      int badWr;
      int badData;
      wait (expQ.size() != 0);
      monBusy = 1'b1;
      it = expQ.pop_front();
      n = 0; wrCnt = 0; badWr = 0; badData = 0;
      do begin
        @(negedge clk);
        n++;
        if (arrWrEn) begin
          wrCnt++;
          if (!((it.onesMask | it.dcMask) >> arrWrBlk & 1)) badWr++;
          if (arrWrData != {WW{1'b1}}) badData++;
        end
      end while (!done && n < 400);
      if (it.expCyc > 0)
        check(n == it.expCyc, "R7", {it.tag, " done latency"}, n, it.expCyc);
      check(pass == it.expPass, "R8", {it.tag, " pass"}, pass, it.expPass);
      check(badWr == 0, "R11", {it.tag, " writes outside snapshot"}, badWr, 0);
      check(badData == 0, "R1", {it.tag, " write data"}, badData, 0);
      if (it.chkCount)
        check(wrCnt == $countones(it.onesMask) * WORDS, "R11",
              {it.tag, " write count"}, wrCnt, $countones(it.onesMask) * WORDS);
      for (int b = 0; b < NBLK; b++) begin
        if (!it.dcMask[b]) begin
          int bad;
          logic [WW-1:0] want;
          want = it.onesMask[b] ? {WW{1'b1}} : '0;
          bad = 0;
          for (int w = 0; w < WORDS; w++) begin
            rdBlk  = BLK_W'(b);
            rdWord = IDX_W'(w);
            #0.1;
            if (rdData != want) bad++;
          end
          check(bad == 0, it.onesMask[b] ? "R1" : (b == NBLK - 1 ? "R3" : "R4"),
                $sformatf("%s block %0d contents", it.tag, b), bad, 0);
        end
      end
      monBusy = 1'b0;
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish();
  end

  task automatic doReset();
    rstN = 1'b0; eraseSel = 1'b0; hvEn = 1'b0; maskWrEn = 1'b0;
    maskWrData = '0; lockMask = '0; rdBlk = '0; rdWord = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic setMask(input logic [NBLK-1:0] m);
    @(negedge clk);
    maskWrEn = 1'b1; maskWrData = m;
    @(negedge clk);
    maskWrEn = 1'b0;
  endtask

  task automatic waitMon();
    wait (expQ.size() == 0);
    wait (!monBusy);
  endtask

  // full erase run; abortAt > 0 drops hvEn after that many negedges
  task automatic runErase(input string tag, input logic [NBLK-1:0] m,
                          input logic [NBLK-1:0] lk, input bit esel,
                          input logic [NBLK-1:0] ones, input logic [NBLK-1:0] dc,
                          input int expCyc, input bit expPass, input int abortAt);
    expItem_t it;
    doReset();
    setMask(m);
    lockMask = lk;
    eraseSel = esel;
    @(negedge clk);
    hvEn = 1'b1;
    it.tag = tag; it.expCyc = expCyc; it.expPass = expPass;
    it.onesMask = ones; it.dcMask = dc; it.chkCount = (abortAt == 0);
    expQ.push_back(it);
    if (abortAt > 0) begin
      repeat (abortAt) @(negedge clk);
      hvEn = 1'b0;
    end
    waitMon();
    @(negedge clk);
    hvEn = 1'b0;
    @(negedge clk);
    eraseSel = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    // R12: reset state
    doReset();
    check(done == 1'b1, "R12", "done after reset", done, 1);
    check(pass == 1'b0, "R12", "pass after reset", pass, 0);
    check(selMask == '0, "R12", "mask after reset", selMask, 0);
    rdBlk = BLK_W'(1); rdWord = IDX_W'(2);
    #0.1;
    check(rdData == '0, "R12", "array after reset", rdData, 0);

    // R1 R7 R8: one low block
    runErase("R1 single", 5'b00001, '0, 1'b1, 5'b00001, '0, CYC + 1, 1'b1, 0);
    // R2: low, mid and shadow in one sequence
    runErase("R2 mixed", 5'b01110, '0, 1'b1, 5'b01110, '0, 3 * CYC + 1, 1'b1, 0);
    // R2: all erasable blocks
    runErase("R2 all", 5'b01111, '0, 1'b1, 5'b01111, '0, 4 * CYC + 1, 1'b1, 0);
    // R3: test block selected with a low block
    runErase("R3 with test", 5'b10001, '0, 1'b1, 5'b00001, '0, CYC + 1, 1'b1, 0);
    // R3 R6: only the test block selected
    runErase("R6 test only", 5'b10000, '0, 1'b1, '0, '0, 1, 1'b0, 0);
    // R4: locked block skipped
    runErase("R4 locked", 5'b00011, 5'b00010, 1'b1, 5'b00001, '0, CYC + 1, 1'b1, 0);
    // R4 R6: every selected block locked
    runErase("R6 all locked", 5'b01000, 5'b01000, 1'b1, '0, '0, 1, 1'b0, 0);
    // R5: enable edge without erase-select
    runErase("R5 no esel", 5'b00111, '0, 1'b0, '0, '0, 1, 1'b0, 0);
    // R9: abort mid-sequence; hvEn low at negedge 8 -> done at negedge 9
    runErase("R9 abort", 5'b00111, '0, 1'b1, '0, 5'b00111, 9, 1'b0, 8);

    // R10: mask writes ignored with HV on, cleared on erase-select fall
    doReset();
    eraseSel = 1'b1;
    setMask(5'b00110);
    check(selMask == 5'b00110, "R10", "mask write with HV off", selMask, 5'b00110);
    hvEn = 1'b1;
    setMask(5'b01001);
    check(selMask == 5'b00110, "R10", "mask write ignored with HV on", selMask, 5'b00110);
    hvEn = 1'b0;
    @(negedge clk);
    eraseSel = 1'b0;
    maskWrEn = 1'b1; maskWrData = 5'b00011;
    @(negedge clk);
    maskWrEn = 1'b0;
    check(selMask == '0, "R10", "mask cleared on erase-select fall", selMask, 0);

    repeat (2) @(negedge clk);
    finish();
  end

endmodule